// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block watches an accelerator's activity and counts it. Four 32-bit event counters each follow one line of an incoming event pulse vector, chosen by a per-counter select register. A free-running 64-bit cycle counter sits beside them. Software reaches everything through a small register bus. A single write strobe or read strobe, a byte address and a 32-bit data word make up each access. Read data comes back on the clock after the read strobe.

The enable mask, the sticky overflow flags and the overflow interrupt enables share one mask layout. Bits 0 to 3 select event counters 0 to 3 and bit 31 selects the cycle counter. Each of the three masks is reached through a write-ones-to-set address and a write-ones-to-clear address. A counter that wraps from all ones to zero raises its overflow flag. The unit's one interrupt line is high while an enabled flag is pending. Software can zero the counters in groups through the control register, or preload any counter directly.

Top module: `perfmon_unit`

## Requirements
- R1: After a synchronous reset, every register reads zero: control 0x00, the mask registers and all counters. The interrupt output is low.
- R2: A select register (0x60 + 4*i for counter i) holds 32 bits. Value 0 counts nothing and value 1 counts every clock. A value 2+k counts clocks on which event input k is high. Values of 2 plus the event width and above count nothing.
- R3: A counter advances only on a clock where control bit 0 (run) is set and its own enable bit is set. Event counters are at 0x40 + 4*i and the cycle counter advances every such clock.
- R4: Writing ones to 0x08 sets enable bits and writing ones to 0x0C clears them; zero bits leave state unchanged. Reading 0x08 returns the enable mask with counters 0..3 in bits 0..3 and the cycle counter in bit 31. Reserved bits read zero.
- R5: Writing 1 to control bit 1 zeroes all event counters, and writing 1 to control bit 2 zeroes the cycle counter. These bits read back as zero, and a zeroing wins over an increment in the same clock.
- R6: A bus write to an event counter loads the written value and takes priority over a hardware increment in the same clock.
- R7: The 64-bit cycle counter has its low word at 0x20 and its high word at 0x24. Each word can be preloaded on its own, and an increment carries from the low word into the high word.
- R8: A counter that wraps from all ones to zero sets its sticky overflow flag at the same clock edge. Reading 0x18 returns the flags in the mask layout. Writing ones to 0x18 sets flags, writing ones to 0x1C clears them, and a hardware wrap wins over a clear.
- R9: Writing ones to 0x10 sets interrupt enables and writing ones to 0x1C's neighbour 0x14 clears them; reading 0x10 returns the enables. The interrupt output is registered. It is high one clock after any flag is set together with its enable.
- R10: Read data appears on the bus one clock after the read strobe, and addresses with no readable register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | EVT_W | Hardware event pulses, one bit per source |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the clock after bus_rd_en |
| irq | output | 1 | Level interrupt: enabled overflow pending |

## Verification
A wrong enable bit, a bad select decode or a lost increment shows up as a counter value that is off. This is visible one clock after the counter address is read, and the bench predicts each count from the event patterns it drives. A missed or stale overflow flag shows on the interrupt line one clock after the flag or enable changes, and on the next read of the flag register. Priority mistakes between zeroing, preload and increment leave a value one count away from the expected one, and that value is read back right after the colliding clock.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

  localparam int unsigned ADDR_W = 8;

  // register byte addresses
  localparam logic [ADDR_W-1:0] A_CTRL     = 8'h00;
  localparam logic [ADDR_W-1:0] A_EN_SET   = 8'h08;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_IE_SET   = 8'h10;
  localparam logic [ADDR_W-1:0] A_IE_CLR   = 8'h14;
  localparam logic [ADDR_W-1:0] A_OV_SET   = 8'h18;
  localparam logic [ADDR_W-1:0] A_OV_CLR   = 8'h1C;
  localparam logic [ADDR_W-1:0] A_CYC_LO   = 8'h20;
  localparam logic [ADDR_W-1:0] A_CYC_HI   = 8'h24;
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 8'h40;
  localparam logic [ADDR_W-1:0] A_SEL_BASE = 8'h60;

  // control bit positions
  localparam int unsigned CTL_RUN     = 0;
  localparam int unsigned CTL_ZAP_EVT = 1;
  localparam int unsigned CTL_ZAP_CYC = 2;

  // decoded write strobes from the register block
  typedef struct packed {
    logic zap_evt;
    logic zap_cyc;
    logic cyc_lo_we;
    logic cyc_hi_we;
  } ctl_strobe_t;

endpackage

// File: rtl/perfmon_evt_cnt.sv
module perfmon_evt_cnt #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EVT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic              run,
  input  logic              zap,
  input  logic              cnt_we,
  input  logic              sel_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] sel_q,
  output logic              wrap
);

  logic hit;
  logic step;

  // select decode: 0 none, 1 every clock, 2+k event line k, beyond: none
  always_comb begin
    hit = (sel_q == DATA_W'(1));
    for (int k = 0; k < int'(EVT_W); k++) begin
      if (sel_q == DATA_W'(k + 2)) hit = evt_in[k];
    end
  end

  assign step = run && hit && !zap && !cnt_we;
  assign wrap = step && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (sel_we) begin
      sel_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || zap) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= wdata;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/perfmon_cyc_cnt.sv
module perfmon_cyc_cnt #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CYC_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              zap,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CYC_W-1:0]  cyc_q,
  output logic              wrap
);

  localparam int unsigned HI_W = CYC_W - DATA_W;

  logic step;

  assign step = run && !zap && !lo_we && !hi_we;
  assign wrap = step && (&cyc_q);

  always_ff @(posedge clk) begin
    if (rst || zap) begin
      cyc_q <= '0;
    end else if (lo_we || hi_we) begin
      if (lo_we) cyc_q[DATA_W-1:0] <= wdata;
      if (hi_we) cyc_q[CYC_W-1:DATA_W] <= wdata[HI_W-1:0];
    end else if (step) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

endmodule

// File: rtl/perfmon_regs.sv
module perfmon_regs
  import perfmon_pkg::*;
#(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CYC_W   = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [2:0]                wctl,
  input  logic [NUM_CNT:0]          wmask,
  input  logic [NUM_CNT-1:0]        evt_wrap,
  input  logic                      cyc_wrap,
  input  logic [NUM_CNT*DATA_W-1:0] cnt_flat,
  input  logic [NUM_CNT*DATA_W-1:0] sel_flat,
  input  logic [CYC_W-1:0]          cyc_val,
  output ctl_strobe_t               strobe,
  output logic [NUM_CNT-1:0]        cnt_we,
  output logic [NUM_CNT-1:0]        sel_we,
  output logic                      run_q,
  output logic [NUM_CNT:0]          en_q,
  output logic [NUM_CNT:0]          ien_q,
  output logic [NUM_CNT:0]          ovf_q,
  output logic [DATA_W-1:0]         rdata_q,
  output logic                      irq_q
);

  localparam int unsigned HI_W = CYC_W - DATA_W;

  logic [NUM_CNT:0]  en_set_m, en_clr_m, ie_set_m, ie_clr_m, ov_set_m, ov_clr_m;
  logic [NUM_CNT:0]  hw_wrap;
  logic              wr_ctl;
  logic [DATA_W-1:0] rd_mux;

  function automatic logic [DATA_W-1:0] spread(input logic [NUM_CNT:0] m);
    logic [DATA_W-1:0] v;
    v = '0;
    v[NUM_CNT-1:0] = m[NUM_CNT-1:0];
    v[DATA_W-1]    = m[NUM_CNT];
    return v;
  endfunction

  assign wr_ctl   = wr_en && (addr == A_CTRL);
  assign en_set_m = (wr_en && addr == A_EN_SET) ? wmask : '0;
  assign en_clr_m = (wr_en && addr == A_EN_CLR) ? wmask : '0;
  assign ie_set_m = (wr_en && addr == A_IE_SET) ? wmask : '0;
  assign ie_clr_m = (wr_en && addr == A_IE_CLR) ? wmask : '0;
  assign ov_set_m = (wr_en && addr == A_OV_SET) ? wmask : '0;
  assign ov_clr_m = (wr_en && addr == A_OV_CLR) ? wmask : '0;
  assign hw_wrap  = {cyc_wrap, evt_wrap};

  assign strobe.zap_evt   = wr_ctl && wctl[CTL_ZAP_EVT];
  assign strobe.zap_cyc   = wr_ctl && wctl[CTL_ZAP_CYC];
  assign strobe.cyc_lo_we = wr_en && (addr == A_CYC_LO);
  assign strobe.cyc_hi_we = wr_en && (addr == A_CYC_HI);

  for (genvar i = 0; i < int'(NUM_CNT); i++) begin : g_strobe
    assign cnt_we[i] = wr_en && (addr == ADDR_W'(A_CNT_BASE + 4 * i));
    assign sel_we[i] = wr_en && (addr == ADDR_W'(A_SEL_BASE + 4 * i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      en_q  <= '0;
      ien_q <= '0;
      ovf_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_ctl) run_q <= wctl[CTL_RUN];
      en_q  <= (en_q  | en_set_m) & ~en_clr_m;
      ien_q <= (ien_q | ie_set_m) & ~ie_clr_m;
      // a wrap in the same clock as a clear is kept
      ovf_q <= (ovf_q & ~ov_clr_m) | ov_set_m | hw_wrap;
      irq_q <= |(ovf_q & ien_q);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_CTRL)   rd_mux[CTL_RUN] = run_q;
    if (addr == A_EN_SET) rd_mux = spread(en_q);
    if (addr == A_IE_SET) rd_mux = spread(ien_q);
    if (addr == A_OV_SET) rd_mux = spread(ovf_q);
    if (addr == A_CYC_LO) rd_mux = cyc_val[DATA_W-1:0];
    if (addr == A_CYC_HI) rd_mux = DATA_W'(cyc_val[CYC_W-1 -: HI_W]);
    for (int i = 0; i < int'(NUM_CNT); i++) begin
      if (addr == ADDR_W'(A_CNT_BASE + 4 * i)) rd_mux = cnt_flat[i*DATA_W +: DATA_W];
      if (addr == ADDR_W'(A_SEL_BASE + 4 * i)) rd_mux = sel_flat[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_mux;
    end
  end

endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CYC_W   = 64,
  parameter int unsigned EVT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int unsigned FLAT_W = NUM_CNT * DATA_W;

  ctl_strobe_t        strobe;
  logic [NUM_CNT-1:0] cnt_we, sel_we, evt_wrap;
  logic               glob_run, cyc_wrap;
  logic [NUM_CNT:0]   en_mask, ien_mask, ovf_mask, wmask;
  logic [FLAT_W-1:0]  cnt_flat, sel_flat;
  logic [CYC_W-1:0]   cyc_val;

  assign wmask = {bus_wdata[DATA_W-1], bus_wdata[NUM_CNT-1:0]};

  perfmon_regs #(
    .NUM_CNT(NUM_CNT), .DATA_W(DATA_W), .CYC_W(CYC_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr_en),
    .rd_en    (bus_rd_en),
    .addr     (bus_addr),
    .wctl     (bus_wdata[2:0]),
    .wmask    (wmask),
    .evt_wrap (evt_wrap),
    .cyc_wrap (cyc_wrap),
    .cnt_flat (cnt_flat),
    .sel_flat (sel_flat),
    .cyc_val  (cyc_val),
    .strobe   (strobe),
    .cnt_we   (cnt_we),
    .sel_we   (sel_we),
    .run_q    (glob_run),
    .en_q     (en_mask),
    .ien_q    (ien_mask),
    .ovf_q    (ovf_mask),
    .rdata_q  (bus_rdata),
    .irq_q    (irq)
  );

  for (genvar i = 0; i < int'(NUM_CNT); i++) begin : g_evt
    perfmon_evt_cnt #(
      .DATA_W(DATA_W), .EVT_W(EVT_W)
    ) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .evt_in (evt_in),
      .run    (glob_run && en_mask[i]),
      .zap    (strobe.zap_evt),
      .cnt_we (cnt_we[i]),
      .sel_we (sel_we[i]),
      .wdata  (bus_wdata),
      .cnt_q  (cnt_flat[i*DATA_W +: DATA_W]),
      .sel_q  (sel_flat[i*DATA_W +: DATA_W]),
      .wrap   (evt_wrap[i])
    );
  end

  perfmon_cyc_cnt #(
    .DATA_W(DATA_W), .CYC_W(CYC_W)
  ) u_cyc (
    .clk   (clk),
    .rst   (rst),
    .run   (glob_run && en_mask[NUM_CNT]),
    .zap   (strobe.zap_cyc),
    .lo_we (strobe.cyc_lo_we),
    .hi_we (strobe.cyc_hi_we),
    .wdata (bus_wdata),
    .cyc_q (cyc_val),
    .wrap  (cyc_wrap)
  );

endmodule

// File: rtl/perfmon_chk.sv
module perfmon_chk
  import perfmon_pkg::*;
#(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned DATA_W  = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_wr_en,
  input logic                      bus_rd_en,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      wbit_zap,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic                      irq,
  input logic                      glob_run,
  input logic [NUM_CNT:0]          ovf_mask,
  input logic [NUM_CNT:0]          ien_mask,
  input logic [NUM_CNT*DATA_W-1:0] cnt_flat
);

  localparam logic [DATA_W-1:0] RSV = ~((DATA_W'(1) << (DATA_W - 1)) |
                                        ((DATA_W'(1) << NUM_CNT) - 1'b1));

  // R5
  zap_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == A_CTRL && wbit_zap) |=> (cnt_flat == '0));

  // R5
  ctl_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr == A_CTRL) |=> (bus_rdata[DATA_W-1:1] == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!glob_run && !bus_wr_en) |=> $stable(cnt_flat));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr_en && bus_addr == A_OV_CLR) |=> ((ovf_mask & $past(ovf_mask)) == $past(ovf_mask)));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ien_mask == '0) |=> !irq);

  // R4
  en_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr == A_EN_SET) |=> ((bus_rdata & RSV) == '0));

endmodule

bind perfmon_unit perfmon_chk #(
  .NUM_CNT(NUM_CNT), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr_en (bus_wr_en),
  .bus_rd_en (bus_rd_en),
  .bus_addr  (bus_addr),
  .wbit_zap  (bus_wdata[1]),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .glob_run  (glob_run),
  .ovf_mask  (ovf_mask),
  .ien_mask  (ien_mask),
  .cnt_flat  (cnt_flat)
);

// File: tb/perfmon_unit_bench.sv
module perfmon_unit_bench;

  localparam int EVT_W = 16;
  localparam logic [7:0] CTRL = 8'h00, EN_S = 8'h08, EN_C = 8'h0C, IE_S = 8'h10,
                         IE_C = 8'h14, OV_S = 8'h18, OV_C = 8'h1C, CYC_L = 8'h20,
                         CYC_H = 8'h24, CNT0 = 8'h40, SEL0 = 8'h60;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [EVT_W-1:0] evt_in = '0;
  logic             bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [7:0]       bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             irq;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int    n_cmp = 0, n_bad = 0;
  logic  rd_pend = 1'b0;
  bit    done = 0;

  always #4 clk = ~clk;

  perfmon_unit #(.EVT_W(EVT_W)) u_perfmon_unit (
    .clk(clk), .rst(rst), .evt_in(evt_in), .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: read data is valid at the falling edge after the capturing edge
  always @(posedge clk) rd_pend <= bus_rd_en;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10 unexpected read data %h, expected none", bus_rdata);
      end else begin
        item_t it;
        it = q.pop_front();
        n_cmp++;
        if (bus_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq actual %b expected %b", tag, irq, e);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired, actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned e0, e1;
    logic [15:0] pat;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(CTRL, 32'h0, "R1 ctrl");
    rd(EN_S, 32'h0, "R1 enable");
    rd(OV_S, 32'h0, "R1 overflow");
    rd(IE_S, 32'h0, "R1 irq enable");
    rd(CNT0, 32'h0, "R1 counter0");
    rd(CYC_L, 32'h0, "R1 cycle low");
    chk_irq(1'b0, "R1");

    // R4 set/clear masks, reserved bits, zero bits keep state
    wr(EN_S, 32'hFFFF_FFFF);
    rd(EN_S, 32'h8000_000F, "R4 set all");
    wr(EN_C, 32'h0000_000A);
    rd(EN_S, 32'h8000_0005, "R4 clear 1,3");
    wr(EN_C, 32'h0);
    rd(EN_S, 32'h8000_0005, "R4 zero write");
    wr(EN_S, 32'h0000_000A);
    rd(EN_S, 32'h8000_000F, "R4 set back");
    rd(EN_C, 32'h0, "R10 clear reg reads zero");

    // R2 select decode: every clock, event line 3, none, out of range
    wr(SEL0 + 8'h0, 32'd1);
    wr(SEL0 + 8'h4, 32'd5);
    wr(SEL0 + 8'h8, 32'd0);
    wr(SEL0 + 8'hC, 32'd200);
    rd(SEL0 + 8'h4, 32'd5, "R2 select readback");
    e1 = 0;
    wr(CTRL, 32'h1);
    for (int i = 0; i < 20; i++) begin
      pat = 16'(i * 7 + 3);
      evt_in = pat;
      if (pat[3]) e1++;
      @(negedge clk);
    end
    evt_in = '0;
    wr(CTRL, 32'h0);
    e0 = 21;
    rd(CNT0 + 8'h0, e0, "R2 every clock");
    rd(CNT0 + 8'h4, e1, "R2 event line 3");
    rd(CNT0 + 8'h8, 32'h0, "R2 select zero");
    rd(CNT0 + 8'hC, 32'h0, "R2 out of range");

    // R3 per-counter enable and global run
    wr(EN_C, 32'h1);
    wr(CTRL, 32'h1);
    repeat (5) @(negedge clk);
    wr(CTRL, 32'h0);
    rd(CNT0, e0, "R3 counter disabled");
    evt_in = '1;
    repeat (10) @(negedge clk);
    evt_in = '0;
    rd(CNT0 + 8'h4, e1, "R3 run off");

    // R5 zeroing wins over increment, reset bits read zero
    wr(EN_S, 32'hF);
    wr(CTRL, 32'h1);
    repeat (3) @(negedge clk);
    wr(CTRL, 32'h2);
    rd(CNT0, 32'h0, "R5 zero beats increment");
    rd(CTRL, 32'h0, "R5 ctrl after zap");
    wr(CTRL, 32'h7);
    rd(CTRL, 32'h1, "R5 reset bits read zero");
    wr(CTRL, 32'h0);

    // R6 preload wins over increment
    wr(CTRL, 32'h1);
    wr(CNT0, 32'd100);
    wr(CTRL, 32'h0);
    rd(CNT0, 32'd101, "R6 preload priority");

    // R8 / R9 overflow and interrupt
    wr(EN_C, 32'hB);
    wr(SEL0 + 8'h8, 32'd1);
    wr(CNT0 + 8'h8, 32'hFFFF_FFFE);
    wr(IE_S, 32'h4);
    rd(IE_S, 32'h4, "R9 irq enable readback");
    chk_irq(1'b0, "R9 no flag");
    wr(CTRL, 32'h1);
    @(negedge clk);
    wr(CTRL, 32'h0);
    rd(CNT0 + 8'h8, 32'h0, "R8 wrapped value");
    rd(OV_S, 32'h4, "R8 flag set");
    chk_irq(1'b1, "R9 raised");
    wr(IE_C, 32'h4);
    @(negedge clk);
    chk_irq(1'b0, "R9 enable cleared");
    rd(OV_S, 32'h4, "R8 flag sticky");
    wr(IE_S, 32'h4);
    @(negedge clk);
    chk_irq(1'b1, "R9 enable again");
    wr(OV_C, 32'h4);
    @(negedge clk);
    chk_irq(1'b0, "R9 flag cleared");
    rd(OV_S, 32'h0, "R8 flag clear");
    wr(OV_S, 32'h8000_0000);
    rd(OV_S, 32'h8000_0000, "R8 software set");
    @(negedge clk);
    chk_irq(1'b0, "R9 unenabled flag");
    wr(OV_C, 32'h8000_0000);

    // R7 cycle counter words and carry, R5 cycle zeroing
    wr(CYC_L, 32'hFFFF_FFFF);
    wr(CYC_H, 32'h0000_0001);
    rd(CYC_L, 32'hFFFF_FFFF, "R7 low preload");
    rd(CYC_H, 32'h1, "R7 high preload");
    wr(CTRL, 32'h1);
    wr(CTRL, 32'h0);
    rd(CYC_L, 32'h0, "R7 carry low");
    rd(CYC_H, 32'h2, "R7 carry high");
    wr(CTRL, 32'h4);
    rd(CYC_H, 32'h0, "R5 cycle zeroed");
    rd(CNT0, 32'd101, "R5 event kept");
    wr(CYC_L, 32'hFFFF_FFFF);
    wr(CYC_H, 32'hFFFF_FFFF);
    wr(CTRL, 32'h1);
    wr(CTRL, 32'h0);
    rd(CYC_L, 32'h0, "R8 cycle wrap");
    rd(OV_S, 32'h8000_0000, "R8 cycle flag");

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule